// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from three sources for a small 8-bit processor core: a falling edge on an external interrupt pin and overflow pulses from two timers. Each source has a pending flag and an enable bit. A master enable gates all three. Software reaches these bits through one 8-bit control/status register on a simple write/read register bus.

Pending, enabled requests are arbitrated by fixed priority only when the core presents a sampling strobe. A winning request produces a one-cycle call request that carries a 4-bit vector address. Taking a call clears the winner's flag and the master enable, so nesting is held off until the core reports a return-from-interrupt. No call is issued while the core reports that its call stack is full. An ordinary subroutine return does not touch the enables.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset, the register reads 0x00 and `call_req` is low.
- R2: The register layout is: bit 0 master enable, bit 1 external enable, bit 2 timer0 enable, bit 3 timer1 enable, bit 4 external flag, bit 5 timer0 flag and bit 6 timer1 flag. A write loads bits 0 to 6 from `reg_wdata`. Bit 7 always reads 0, whatever is written to it.
- R3: A high-to-low transition on `ext_irq_n` sets the external flag. A low-to-high transition does not.
- R4: A one-cycle pulse on `tmr0_ovf` sets the timer0 flag, and a pulse on `tmr1_ovf` sets the timer1 flag.
- R5: Among pending, enabled requests, external wins over timer0, and timer0 wins over timer1. The vector on `call_vec` is 0x4 for external, 0x8 for timer0 and 0xC for timer1.
- R6: A request is serviced only when the master enable is 1, the source's own enable is 1 and `stack_full` is low.
- R7: Servicing a request clears that source's flag and the master enable in the same cycle that `call_req` rises. Other pending flags stay set.
- R8: A one-cycle pulse on `reti` sets the master enable. A pulse on `ret_plain` leaves it unchanged.
- R9: Arbitration happens only in a cycle with `sample_stb` high. `call_req` is a single-cycle pulse in the cycle after that strobe. A request that becomes pending between strobes is serviced at the next strobe.
- R10: A flag stays set until it is serviced or a register write clears it.
- R11: If a hardware set event and a register write hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ext_irq_n | input | 1 | External interrupt pin, active on falling edge, asynchronous |
| tmr0_ovf | input | 1 | Timer0 overflow pulse |
| tmr1_ovf | input | 1 | Timer1 overflow pulse |
| sample_stb | input | 1 | Arbitration sampling strobe from the core |
| stack_full | input | 1 | Core call stack is full |
| ret_plain | input | 1 | Core executed an ordinary return |
| reti | input | 1 | Core executed a return-from-interrupt |
| call_req | output | 1 | One-cycle interrupt call request |
| call_vec | output | 4 | Vector address of the call |

## Verification
Every state bit is visible on `reg_rdata` one cycle after the event that changed it, so a wrong flag, enable or master bit shows up at the next read.

A fault in the priority chain or the vector encoding shows on `call_vec` in the cycle after a strobe. The bench therefore drives several request combinations at once and compares both the vector and the flags left behind.

A fault in gating or in the strobe timing shows as an extra or missing `call_req` pulse. The bench checks for this with the stack full, with the master enable off and with a source disabled, and it also checks the cycles between strobes.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC      = 3;
  localparam int VEC_W     = 4;
  localparam int BIT_MEN   = 0;
  localparam int EN_LSB    = 1;
  localparam int FLG_LSB   = EN_LSB + NSRC;
  localparam int REG_W     = 8;
  localparam int PAD_W     = REG_W - 1 - 2 * NSRC;
  localparam int IDX_W     = $clog2(NSRC);

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT = 2'd0,
    SRC_TM0 = 2'd1,
    SRC_TM1 = 2'd2
  } src_e;

  // vector = (index + 1) * 4
  function automatic logic [VEC_W-1:0] src_vector(input logic [IDX_W-1:0] idx);
    logic [VEC_W-1:0] v;
    v = VEC_W'(idx) + VEC_W'(1);
    return v << 2;
  endfunction
endpackage

// File: rtl/irq_pin_fall.sv
module irq_pin_fall #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b1;
        else if (s == 0) sync_q[s] <= pin;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic [NSRC-1:0]  hw_set,
  input  logic [NSRC-1:0]  svc_clr,
  input  logic             svc_take,
  input  logic             reti,
  input  logic             ret_plain,
  output logic             master,
  output logic [NSRC-1:0]  en,
  output logic [NSRC-1:0]  flag,
  output logic [REG_W-1:0] rdata
);
  logic            master_q, master_d;
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] flag_q, flag_d;
  logic            unused_ok;

  assign unused_ok = ^{wdata[REG_W-1], ret_plain};

  always_comb begin
    master_d = master_q;
    en_d     = en_q;
    flag_d   = flag_q;
    if (we) begin
      master_d = wdata[BIT_MEN];
      en_d     = wdata[EN_LSB +: NSRC];
      flag_d   = wdata[FLG_LSB +: NSRC];
    end
    if (reti)     master_d = 1'b1;
    if (svc_take) master_d = 1'b0;
    // hardware set has the last word
    flag_d = (flag_d & ~svc_clr) | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= 1'b0;
      en_q     <= '0;
      flag_q   <= '0;
    end else begin
      master_q <= master_d;
      en_q     <= en_d;
      flag_q   <= flag_d;
    end
  end

  assign master = master_q;
  assign en     = en_q;
  assign flag   = flag_q;
  assign rdata  = {{PAD_W{1'b0}}, flag_q, en_q, master_q};

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_chk
      // R4 R11
      hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hw_set[i] |=> flag_q[i]);
    end
  endgenerate

  // R8
  reti_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && !svc_take) |=> master_q);

  // R8
  plain_ret_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_plain && !reti && !we && !svc_take) |=> $stable(master_q));
endmodule

// File: rtl/irq_pri_sel.sv
module irq_pri_sel
  import irq_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [NSRC-1:0]  grant
);
  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    any   = |req;
    grant = any ? (NSRC'(1) << idx) : '0;
  end

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~req) == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ext_irq_n,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             sample_stb,
  input  logic             stack_full,
  input  logic             ret_plain,
  input  logic             reti,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec
);
  logic             ext_fall;
  logic [NSRC-1:0]  hw_set, svc_clr, pend, grant, en, flag;
  logic             master, any, take;
  logic [IDX_W-1:0] win_idx;
  logic             req_q;
  logic [VEC_W-1:0] vec_q;

  irq_pin_fall #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
    .clk(clk), .rst(rst), .pin(ext_irq_n), .fall(ext_fall)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[SRC_EXT] = ext_fall;
    hw_set[SRC_TM0] = tmr0_ovf;
    hw_set[SRC_TM1] = tmr1_ovf;
  end

  assign pend = flag & en;

  irq_pri_sel u_sel (
    .clk(clk), .rst(rst), .req(pend),
    .any(any), .idx(win_idx), .grant(grant)
  );

  assign take    = sample_stb & master & any & ~stack_full;
  assign svc_clr = take ? grant : '0;

  irq_ctl_reg u_reg (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
    .hw_set(hw_set), .svc_clr(svc_clr), .svc_take(take),
    .reti(reti), .ret_plain(ret_plain),
    .master(master), .en(en), .flag(flag), .rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= take;
      if (take) vec_q <= src_vector(win_idx);
    end
  end

  assign call_req = req_q;
  assign call_vec = vec_q;

  // R9
  req_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
    call_req |-> $past(sample_stb));

  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    call_req |=> !call_req);

  // R6
  no_call_full_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && stack_full) |=> !call_req);

  // R7
  master_off_chk: assert property (@(posedge clk) disable iff (rst)
    call_req |-> !reg_rdata[BIT_MEN]);

  // R5
  vec_legal_chk: assert property (@(posedge clk) disable iff (rst)
    call_req |-> (call_vec[1:0] == 2'b00 && call_vec != '0));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_irq_n = 1'b1;
  logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
  logic       sample_stb = 1'b0, stack_full = 1'b0;
  logic       ret_plain = 1'b0, reti = 1'b0;
  logic       call_req;
  logic [3:0] call_vec;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl dut (.*);

  // {wr[24:17], ev{t1,t0,ext}[16:14], sf[13], req[12], vec[11:8], rd[7:0]}
  localparam int NV = 11;
  localparam logic [24:0] VECS [NV] = '{
    {8'h0F, 3'b100, 1'b0, 1'b1, 4'hC, 8'h0E}, // R4 R5 R7 timer1 alone
    {8'h0F, 3'b111, 1'b0, 1'b1, 4'h4, 8'h6E}, // R5 R7 all three
    {8'h0F, 3'b110, 1'b0, 1'b1, 4'h8, 8'h4E}, // R5 timer0 over timer1
    {8'h0F, 3'b001, 1'b0, 1'b1, 4'h4, 8'h0E}, // R3 external
    {8'h0F, 3'b010, 1'b1, 1'b0, 4'h0, 8'h2F}, // R6 stack full, R10 kept
    {8'h0E, 3'b010, 1'b0, 1'b0, 4'h0, 8'h2E}, // R6 master off
    {8'h0B, 3'b110, 1'b0, 1'b1, 4'hC, 8'h2A}, // R6 timer0 disabled
    {8'h0D, 3'b011, 1'b0, 1'b1, 4'h8, 8'h1C}, // R6 ext disabled
    {8'h8F, 3'b000, 1'b0, 1'b0, 4'h0, 8'h0F}, // R2 bit7 reads 0
    {8'h70, 3'b000, 1'b0, 1'b0, 4'h0, 8'h70}, // R2 flags by write
    {8'h71, 3'b000, 1'b0, 1'b0, 4'h0, 8'h71}  // R6 no enables
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1'b1; reg_wdata = d; tick(1); reg_we = 1'b0;
  endtask

  task automatic ext_fall();
    ext_irq_n = 1'b0; tick(5); ext_irq_n = 1'b1; tick(5);
  endtask

  task automatic strobe(input logic sf);
    sample_stb = 1'b1; stack_full = sf; tick(1);
    sample_stb = 1'b0; stack_full = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3); rst = 1'b0; tick(1);
    check("R1 reset rdata", reg_rdata, 8'h00);
    check("R1 reset call_req", call_req, 1'b0);

    for (int k = 0; k < NV; k++) begin
      logic [24:0] v;
      v = VECS[k];
      wr(v[24:17]);
      if (v[14]) ext_fall();
      tmr0_ovf = v[15]; tmr1_ovf = v[16]; tick(1);
      tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; tick(1);
      strobe(v[13]);
      check($sformatf("R9 R6 vec%0d call_req", k), call_req, v[12]);
      if (v[12]) check($sformatf("R5 vec%0d call_vec", k), call_vec, v[11:8]);
      tick(1);
      check($sformatf("R9 vec%0d pulse end", k), call_req, 1'b0);
      check($sformatf("R7 R10 vec%0d rdata", k), reg_rdata, v[7:0]);
    end

    // R9: pending request waits for the strobe
    begin
      int seen;
      seen = 0;
      wr(8'h05);
      tmr0_ovf = 1'b1; tick(1); tmr0_ovf = 1'b0;
      for (int i = 0; i < 8; i++) begin tick(1); if (call_req) seen++; end
      check("R9 no call between strobes", seen, 0);
      check("R10 flag held", reg_rdata, 8'h25);
      strobe(1'b0);
      check("R9 call at strobe", call_req, 1'b1);
      check("R5 timer0 vector", call_vec, 4'h8);
      tick(1);
    end

    // R8: plain return keeps master off, reti turns it on
    check("R7 master cleared", reg_rdata, 8'h04);
    ret_plain = 1'b1; tick(1); ret_plain = 1'b0; tick(1);
    check("R8 ret_plain no effect", reg_rdata, 8'h04);
    reti = 1'b1; tick(1); reti = 1'b0; tick(1);
    check("R8 reti sets master", reg_rdata, 8'h05);

    // R11: hardware set beats a write in the same cycle
    reg_we = 1'b1; reg_wdata = 8'h00; tmr0_ovf = 1'b1; tick(1);
    reg_we = 1'b0; tmr0_ovf = 1'b0; tick(1);
    check("R11 set wins over write", reg_rdata, 8'h20);

    // R3: rising edge does not set the flag; R10 write clears it
    wr(8'h00);
    ext_irq_n = 1'b0; tick(5);
    check("R3 falling edge sets", reg_rdata, 8'h10);
    wr(8'h00); tick(1);
    check("R10 write clears flag", reg_rdata, 8'h00);
    ext_irq_n = 1'b1; tick(5);
    check("R3 rising edge ignored", reg_rdata, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule